// File: doc/BRIEF.md
# Go-Back-N Retransmission Sender

This block is the sender-side control of a sliding-window repeat-request link with a fixed window of four packets. A producer asks for permission to send a new packet. The block grants it when the window has room, and tags the packet with a 3-bit sequence number. The block watches cumulative acknowledgements from the far end. These are either positive (ACK) or negative (NAK). The block also runs a retransmission timer on the oldest unacknowledged packet.

When a loss is declared, the block rewinds to the oldest unacknowledged packet and replays every packet from there up to the newest one sent. It does this one sequence number per cycle, in order, on the same transmit port. A loss comes from a NAK, or from the timer expiring. While replaying, new requests are stalled.

Payload storage, the link, the receiver and error detection are outside the block. The block emits only the sequence numbers to be (re)sent, a count of packets in flight and a replay flag.

Top module: `gbn_sender`

## Requirements
- R1: After reset the window base and the next new sequence number are both 0, `in_flight` is 0, `replaying` is 0, and `tx_valid` and `new_gnt` are low.
- R2: `new_gnt` is asserted in the same cycle as `new_req` when all of these hold: the block is not replaying, no loss is declared in that cycle, and `in_flight` is below 4. The granted packet appears on `tx_seq` with `tx_valid`=1 and `tx_rtx`=0. Successive new packets take consecutive sequence numbers modulo 8.
- R3: `in_flight` never exceeds 4. With 4 packets outstanding, a request is not granted.
- R4: A valid acknowledgement (either type) for sequence n counts only when n is within the outstanding range. Being in range means (n − base) mod 8 < `in_flight`. Such an acknowledgement moves the base to n+1 mod 8 at the next edge.
- R5: An acknowledgement whose sequence number is outside the outstanding range changes nothing: not `in_flight`, not `replaying`, and not the timer.
- R6: An in-range NAK (`ack_nak`=1) declares a loss in that cycle. If packets remain outstanding after the base moves, replay starts at the next cycle from the new base.
- R7: With packets outstanding, a loss is declared when `timeout_cycles` cycles pass without a base advance, loss or start from empty. Replay then starts from the base. An ACK arriving in the expiry cycle cancels the expiry.
- R8: While `replaying` is 1, the block emits one packet per cycle with `tx_valid`=1 and `tx_rtx`=1. The packets go in increasing modular order up to the newest sent packet, and then `replaying` falls.
- R9: In a cycle where a loss is declared, nothing is transmitted and `new_gnt` is 0, even if `new_req` is high. A loss during a replay restarts the replay from the base.
- R10: If an ACK during replay moves the base past the next replay position, the replay skips ahead to the new base.
- R11: The timer restarts on every base advance and on every loss. With nothing outstanding it stays stopped, so no loss is ever declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_req | input | 1 | Producer asks to send a new packet |
| new_gnt | output | 1 | New packet granted this cycle |
| tx_valid | output | 1 | A packet is sent this cycle |
| tx_seq | output | SEQ_W | Sequence number of the packet sent |
| tx_rtx | output | 1 | The packet sent is a retransmission |
| ack_valid | input | 1 | Acknowledgement present |
| ack_nak | input | 1 | 1 = negative acknowledgement, 0 = positive |
| ack_seq | input | SEQ_W | Cumulative acknowledgement sequence number |
| timeout_cycles | input | TMR_W | Retransmission timeout in cycles (at least 1) |
| in_flight | output | SEQ_W | Packets sent but not yet acknowledged |
| replaying | output | 1 | Replay after a loss is in progress |

## Verification
The assertions rely on two input conditions. `timeout_cycles` is at least 1, and it is held steady while packets are outstanding. The bench sets it only during reset and keeps it constant within each run.

Acknowledgements may name any sequence number. The assertions rely only on the block's own range test, so the bench deliberately mixes out-of-range numbers in with in-range ones. A behavioural model built on unbounded integers predicts every output in every cycle. Directed sequences cover these cases:
- a full window
- an ignored acknowledgement
- a NAK together with a request
- a skip during replay
- a timeout
- an idle period with nothing outstanding

// File: rtl/gbn_sender.sv
module gbn_sender #(
  parameter int SEQ_W = 3,
  parameter int WIN   = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_req,
  output logic             new_gnt,
  output logic             tx_valid,
  output logic [SEQ_W-1:0] tx_seq,
  output logic             tx_rtx,
  input  logic             ack_valid,
  input  logic             ack_nak,
  input  logic [SEQ_W-1:0] ack_seq,
  input  logic [TMR_W-1:0] timeout_cycles,
  output logic [SEQ_W-1:0] in_flight,
  output logic             replaying
);

  localparam logic [SEQ_W-1:0] WIN_V = SEQ_W'(WIN);
  localparam logic [SEQ_W-1:0] ONE   = SEQ_W'(1);

  logic [SEQ_W-1:0] base_q, hi_q, rp_q;
  logic             rpl_q;
  logic [TMR_W-1:0] tmr_q;

  logic [SEQ_W-1:0] out_cnt, ack_off, base_nx, hi_nx, rp_step, rp_nx;
  logic             ack_hit, tmr_exp, loss, rpl_nx, skip;
  logic [TMR_W-1:0] tmr_nx;

  assign out_cnt = hi_q - base_q;
  assign ack_off = ack_seq - base_q;
  assign ack_hit = ack_valid && (ack_off < out_cnt);
  assign tmr_exp = (out_cnt != '0) &&
                   (({1'b0, tmr_q} + 1'b1) >= {1'b0, timeout_cycles});
  assign loss    = (ack_hit && ack_nak) || (tmr_exp && !ack_hit);

  assign new_gnt   = new_req && !rpl_q && !loss && (out_cnt < WIN_V);
  assign tx_rtx    = rpl_q && !loss;
  assign tx_valid  = new_gnt || tx_rtx;
  assign tx_seq    = rpl_q ? rp_q : hi_q;
  assign in_flight = out_cnt;
  assign replaying = rpl_q;

  assign base_nx = ack_hit ? ack_seq + ONE : base_q;
  assign hi_nx   = hi_q + SEQ_W'(new_gnt);
  assign rp_step = rp_q + ONE;
  assign skip    = ack_hit && ((rp_step - base_q) < (base_nx - base_q));

  always_comb begin
    if (loss) begin
      rp_nx  = base_nx;
      rpl_nx = (base_nx != hi_q);
    end else if (rpl_q) begin
      rp_nx  = skip ? base_nx : rp_step;
      rpl_nx = (rp_nx != hi_q);
    end else begin
      rp_nx  = hi_nx;
      rpl_nx = 1'b0;
    end
  end

  always_comb begin
    if (hi_nx == base_nx)
      tmr_nx = '0;
    else if (ack_hit || loss || out_cnt == '0)
      tmr_nx = '0;
    else if (tmr_q != '1)
      tmr_nx = tmr_q + 1'b1;
    else
      tmr_nx = tmr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      hi_q   <= '0;
      rp_q   <= '0;
      rpl_q  <= 1'b0;
      tmr_q  <= '0;
    end else begin
      base_q <= base_nx;
      hi_q   <= hi_nx;
      rp_q   <= rp_nx;
      rpl_q  <= rpl_nx;
      tmr_q  <= tmr_nx;
    end
  end

endmodule

// File: rtl/gbn_sender_chk.sv
module gbn_sender_chk #(
  parameter int SEQ_W = 3,
  parameter int WIN   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             new_req,
  input logic             new_gnt,
  input logic             tx_valid,
  input logic             tx_rtx,
  input logic             ack_valid,
  input logic [SEQ_W-1:0] in_flight,
  input logic             replaying
);

  p_window_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight <= SEQ_W'(WIN));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_flight == SEQ_W'(WIN)) |-> !new_gnt);

  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_gnt |-> (new_req && tx_valid && !tx_rtx));

  p_grant_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (new_gnt && !ack_valid) |=> (in_flight == $past(in_flight) + 1'b1));

  p_rtx_in_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rtx |-> replaying);

  p_no_new_in_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    replaying |-> !new_gnt);

  p_loss_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replaying) |-> $past(!tx_valid));

  p_no_ack_no_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_valid && !new_gnt) |=> (in_flight == $past(in_flight)));

endmodule

bind gbn_sender gbn_sender_chk #(.SEQ_W(SEQ_W), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .new_req(new_req), .new_gnt(new_gnt),
  .tx_valid(tx_valid), .tx_rtx(tx_rtx), .ack_valid(ack_valid),
  .in_flight(in_flight), .replaying(replaying)
);

// File: tb/gbn_sender_tb.sv
module gbn_sender_tb_top;
  localparam int SEQ_W = 3;
  localparam int TMR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic new_req = 1'b0, ack_valid = 1'b0, ack_nak = 1'b0;
  logic [SEQ_W-1:0] ack_seq = '0;
  logic [TMR_W-1:0] timeout_cycles = 16'd20;
  logic new_gnt, tx_valid, tx_rtx, replaying;
  logic [SEQ_W-1:0] tx_seq, in_flight;

  always #10 clk = ~clk;

  gbn_sender #(.SEQ_W(SEQ_W), .WIN(4), .TMR_W(TMR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .new_req(new_req), .new_gnt(new_gnt),
    .tx_valid(tx_valid), .tx_seq(tx_seq), .tx_rtx(tx_rtx),
    .ack_valid(ack_valid), .ack_nak(ack_nak), .ack_seq(ack_seq),
    .timeout_cycles(timeout_cycles), .in_flight(in_flight),
    .replaying(replaying));

  int checks = 0, errors = 0;
  int m_base, m_hi, m_rp, m_age, tmo;
  bit m_rpl;
  bit seen_rpl;

  function automatic int mod8(int v);
    return ((v % 8) + 8) % 8;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_base = 0; m_hi = 0; m_rp = 0; m_rpl = 0; m_age = 0;
  endtask

  // drive one cycle, compare against the model, then advance the model
  task automatic cyc(bit rq, bit av, bit nk, int sq);
    int out, off, nb, nh, step;
    bit hit, exp_t, loss, gnt, txv, rtx;
    @(negedge clk);
    new_req = rq; ack_valid = av; ack_nak = nk; ack_seq = SEQ_W'(sq);
    #1;
    out   = m_hi - m_base;
    off   = mod8(sq - m_base);
    hit   = av && (off < out);
    exp_t = (out > 0) && (m_age + 1 >= tmo);
    loss  = (hit && nk) || (exp_t && !hit);
    gnt   = rq && !m_rpl && !loss && (out < 4);
    rtx   = m_rpl && !loss;
    txv   = gnt || rtx;
    chk(new_gnt == gnt, "R2/R3/R9 new_gnt", new_gnt, gnt);
    chk(tx_valid == txv, "R8/R9 tx_valid", tx_valid, txv);
    chk(tx_rtx == rtx, "R8 tx_rtx", tx_rtx, rtx);
    if (txv) chk(int'(tx_seq) == mod8(m_rpl ? m_rp : m_hi),
                 "R2/R8/R10 tx_seq", tx_seq, mod8(m_rpl ? m_rp : m_hi));
    chk(int'(in_flight) == out, "R3/R4/R5 in_flight", in_flight, out);
    chk(replaying == m_rpl, "R6/R7/R11 replaying", replaying, m_rpl);
    if (replaying) seen_rpl = 1;
    nb = hit ? m_base + off + 1 : m_base;
    nh = m_hi + (gnt ? 1 : 0);
    if (loss) begin
      m_rp = nb; m_rpl = (nb != m_hi);
    end else if (m_rpl) begin
      step = m_rp + 1;
      if (hit && step < nb) step = nb;
      m_rp = step; m_rpl = (step != m_hi);
    end else begin
      m_rp = nh; m_rpl = 0;
    end
    if (nh == nb) m_age = 0;
    else if (hit || loss || out == 0) m_age = 0;
    else m_age++;
    m_base = nb; m_hi = nh;
  endtask

  task automatic do_reset(int t);
    @(negedge clk);
    rst_n = 0; new_req = 0; ack_valid = 0; ack_nak = 0; timeout_cycles = TMR_W'(t);
    tmo = t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      int out, sq, r;
      bit av;
      out = m_hi - m_base;
      r = $urandom % 100;
      av = (r < 30);
      if (out > 0 && r < 25) sq = mod8(m_base + int'($urandom % out));
      else sq = int'($urandom % 8);
      cyc(($urandom % 100) < 60, av, ($urandom % 4) == 0, sq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(20);
    // R1: reset state
    cyc(0, 0, 0, 0);
    chk(in_flight == 0 && !replaying && !tx_valid && !new_gnt, "R1 reset state",
        {in_flight, replaying, tx_valid}, 0);
    // R2: four new packets 0..3
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 0, 0);
      chk(new_gnt && tx_seq == SEQ_W'(i) && !tx_rtx, "R2 grant seq", tx_seq, i);
    end
    // R3: window full
    cyc(1, 0, 0, 0);
    chk(!new_gnt && in_flight == 4, "R3 full window stall", in_flight, 4);
    // R4: ACK seq 1
    cyc(0, 1, 0, 1);
    cyc(0, 0, 0, 0);
    chk(in_flight == 2, "R4 cumulative ack", in_flight, 2);
    // R5: ack for seq 7 is out of range
    cyc(0, 1, 1, 7);
    cyc(0, 0, 0, 0);
    chk(in_flight == 2 && !replaying, "R5 out-of-range ignored", in_flight, 2);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    // R9: NAK seq 2 together with a request
    cyc(1, 1, 1, 2);
    chk(!new_gnt && !tx_valid, "R9 loss beats request", new_gnt, 0);
    // R6: replay starts from 3; ACK 4 in this cycle forces a skip (R10)
    cyc(1, 1, 0, 4);
    chk(replaying && tx_rtx && tx_seq == 3, "R6 replay from new base", tx_seq, 3);
    cyc(1, 0, 0, 0);
    chk(tx_rtx && tx_seq == 5, "R10 replay skips acked", tx_seq, 5);
    cyc(0, 0, 0, 0);
    chk(!replaying && in_flight == 1, "R8 replay ends at newest", replaying, 0);
    // R7: timeout on seq 5
    seen_rpl = 0;
    repeat (25) cyc(0, 0, 0, 0);
    chk(seen_rpl, "R7 timeout replay", seen_rpl, 1);
    // R11: acknowledge all, then idle long
    cyc(0, 1, 0, 5);
    seen_rpl = 0;
    repeat (70) cyc(0, 0, 0, 0);
    chk(!seen_rpl && in_flight == 0, "R11 timer stopped when empty", seen_rpl, 0);
    random_run(4000);
    do_reset(6);
    cyc(0, 0, 0, 0);
    chk(in_flight == 0 && !replaying, "R1 reset state second run", in_flight, 0);
    random_run(6000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule